// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block evaluates a set of Boolean functions in sum-of-products form. The functions are not fixed when the chip is built. They are loaded at run time over a one-bit serial configuration port. The array has two programmable planes. In the first plane, every product term chooses for each input one of four settings: the input itself, its inverse, no connection, or a setting that forces the term to zero. In the second plane, every output chooses any subset of the product terms and ORs them together. One product term can feed several outputs, so logic that two functions have in common is built only once.

To program the array, raise `cfg_en` and present one configuration bit per clock on `cfg_data`. While loading is under way the outputs stay at zero. Once the last expected bit has been taken, `cfg_done` rises. From then on the outputs follow `pla_in` through combinational logic only. The number of inputs, product terms and outputs are parameters. Only functions that fit within the product-term budget can be programmed.

Top module: `pla_core`

## Requirements
- R1: A product-term entry of 01 makes that term require its input to be 1. An entry of 10 makes the term require the input to be 0.
- R2: An entry of 00 leaves the input out of the term, so a term whose entries are all 00 evaluates to 1. An entry of 11 forces the whole term to 0.
- R3: Each output is the OR of the product terms its select bits enable. An output with no terms selected is 0, and a single term may drive any number of outputs.
- R4: Configuration bits enter most significant bit first. Together they form a vector of N_PT*N_IN*2 + N_OUT*N_PT bits, with the product-term plane in the upper part. The entry for term t and input i sits at bits OR_BITS+2*(t*N_IN+i)+1 and OR_BITS+2*(t*N_IN+i), where OR_BITS = N_OUT*N_PT. The select bit for output o and term t sits at bit o*N_PT+t. The configuration does not change while `cfg_en` is low.
- R5: `cfg_done` is 0 in the cycle right after the last expected bit is taken and 1 from the following clock edge. It clears at the first clock edge at which `cfg_en` is seen high after having been low.
- R6: `pla_out` is all zeros whenever `cfg_en` is high or `cfg_done` is low, including after a load that was abandoned before all bits arrived.
- R7: Bits presented with `cfg_en` high after the expected total has been received within one load are ignored.
- R8: With `cfg_done` high and `cfg_en` low, `pla_out` changes in the same cycle as `pla_in`, without passing through any register.
- R9: Reset clears the configuration and `cfg_done`, and `pla_out` is then all zeros for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | High while configuration bits are being shifted in |
| cfg_data | input | 1 | Serial configuration bit, most significant first |
| pla_in | input | N_IN | Function inputs |
| pla_out | output | N_OUT | Function outputs |
| cfg_done | output | 1 | Full configuration received |

## Verification
The bench builds the array with three inputs, four product terms and two outputs. At this size the configuration is 32 bits long, and every input combination can be swept after every load. A bench model works out the expected outputs from the bit layout alone. It is applied to hand-built configurations that share terms, use the forcing entry and leave outputs unselected, and to a series of pseudo-random configurations. The small size also keeps load timing, surplus bits and abandoned loads quick to exercise.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Setting of one input within one product term
  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_sel_e;

  function automatic int and_plane_bits(input int n_in, input int n_pt);
    return n_pt * n_in * 2;
  endfunction

  function automatic int or_plane_bits(input int n_pt, input int n_out);
    return n_out * n_pt;
  endfunction

  function automatic int cfg_total_bits(input int n_in, input int n_pt, input int n_out);
    return and_plane_bits(n_in, n_pt) + or_plane_bits(n_pt, n_out);
  endfunction

endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader
  import pla_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_PT  = 16,
  parameter int N_OUT = 4,
  localparam int TOTAL = cfg_total_bits(N_IN, N_PT, N_OUT),
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  output logic [TOTAL-1:0] cfg_vec,
  output logic             cfg_done
);

  localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL);

  logic [TOTAL-1:0] vec_q, vec_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             en_q;
  logic             en_rise;
  logic             take_bit;

  assign en_rise  = cfg_en & ~en_q;
  assign take_bit = cfg_en & (cnt_q != TOTAL_C);

  // next-state logic
  always_comb begin
    vec_n  = vec_q;
    cnt_n  = cnt_q;
    done_n = done_q;
    if (!cfg_en) begin
      cnt_n = '0;
    end else if (take_bit) begin
      vec_n = {vec_q[TOTAL-2:0], cfg_data};
      cnt_n = cnt_q + 1'b1;
    end
    if (en_rise) begin
      done_n = 1'b0;
    end else if (cnt_q == TOTAL_C) begin
      done_n = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q   <= cfg_en;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      if (take_bit) begin
        vec_q <= vec_n;
      end
    end
  end

  assign cfg_vec  = vec_q;
  assign cfg_done = done_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_PT = 16,
  localparam int AND_BITS = and_plane_bits(N_IN, N_PT)
) (
  input  logic [N_IN-1:0]     in_vec,
  input  logic [AND_BITS-1:0] and_cfg,
  output logic [N_PT-1:0]     terms
);

  logic [N_PT-1:0][N_IN-1:0] lit_ok;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      lit_sel_e sel;
      assign sel = lit_sel_e'(and_cfg[(t*N_IN+i)*2 +: 2]);
      always_comb begin
        case (sel)
          LIT_NONE: lit_ok[t][i] = 1'b1;
          LIT_TRUE: lit_ok[t][i] = in_vec[i];
          LIT_COMP: lit_ok[t][i] = ~in_vec[i];
          default:  lit_ok[t][i] = 1'b0;
        endcase
      end
    end
    assign terms[t] = &lit_ok[t];
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_PT  = 16,
  parameter int N_OUT = 4,
  localparam int OR_BITS = or_plane_bits(N_PT, N_OUT)
) (
  input  logic [N_PT-1:0]    terms,
  input  logic [OR_BITS-1:0] or_cfg,
  output logic [N_OUT-1:0]   sums
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sums[o] = |(terms & or_cfg[o*N_PT +: N_PT]);
  end

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_PT  = 16,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  pla_in,
  output logic [N_OUT-1:0] pla_out,
  output logic             cfg_done
);

  localparam int AND_BITS = and_plane_bits(N_IN, N_PT);
  localparam int OR_BITS  = or_plane_bits(N_PT, N_OUT);
  localparam int TOTAL    = AND_BITS + OR_BITS;

  logic [TOTAL-1:0] cfg_vec;
  logic [N_PT-1:0]  terms;
  logic [N_OUT-1:0] sums;
  logic             live;

  pla_cfg_loader #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_data (cfg_data),
    .cfg_vec  (cfg_vec),
    .cfg_done (cfg_done)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_vec  (pla_in),
    .and_cfg (cfg_vec[TOTAL-1:OR_BITS]),
    .terms   (terms)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .terms  (terms),
    .or_cfg (cfg_vec[OR_BITS-1:0]),
    .sums   (sums)
  );

  assign live    = cfg_done & ~cfg_en;
  assign pla_out = live ? sums : '0;

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
  import pla_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_PT  = 16,
  parameter int N_OUT = 4,
  localparam int TOTAL = cfg_total_bits(N_IN, N_PT, N_OUT),
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_done,
  input logic [N_IN-1:0]  pla_in,
  input logic [N_OUT-1:0] pla_out,
  input logic [TOTAL-1:0] cfg_vec
);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (!cfg_en) begin
      seen_q <= '0;
    end else if (seen_q != CNT_W'(TOTAL)) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R6
  out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en || !cfg_done) |-> (pla_out == '0));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en) |=> !cfg_done);

  // R5
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> ($past(seen_q) == CNT_W'(TOTAL)));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_vec));

  // R8
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && cfg_done && $stable(cfg_vec) && $past(!cfg_en && cfg_done)
     && $stable(pla_in)) |-> $stable(pla_out));

endmodule

bind pla_core pla_core_chk #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_done (cfg_done),
  .pla_in   (pla_in),
  .pla_out  (pla_out),
  .cfg_vec  (cfg_vec)
);

// File: tb/tb_pla_core.sv
module tb_pla_core;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int NP = 4;
  localparam int NO = 2;
  localparam int OR_BITS = NO * NP;
  localparam int TOTAL = NP * NI * 2 + OR_BITS;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_data;
  logic [NI-1:0] pla_in;
  logic [NO-1:0] pla_out;
  logic          cfg_done;

  int n_chk;
  int n_bad;
  logic [TOTAL-1:0] img;
  logic [31:0] rng;

  pla_core #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .pla_in(pla_in), .pla_out(pla_out), .cfg_done(cfg_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench model: evaluation from the bit layout of R4
  function automatic logic [NO-1:0] model(input logic [TOTAL-1:0] v, input logic [NI-1:0] x);
    logic [NO-1:0] r;
    r = '0;
    for (int t = 0; t < NP; t++) begin
      logic term;
      term = 1'b1;
      for (int i = 0; i < NI; i++) begin
        logic [1:0] e;
        e = v[OR_BITS + (t*NI+i)*2 +: 2];
        if (e == 2'b11) term = 1'b0;
        if (e == 2'b01 && !x[i]) term = 1'b0;
        if (e == 2'b10 && x[i]) term = 1'b0;
      end
      for (int o = 0; o < NO; o++)
        if (term && v[o*NP+t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  task automatic set_lit(input int t, input int i, input logic [1:0] e);
    img[OR_BITS + (t*NI+i)*2 +: 2] = e;
  endtask

  task automatic set_sel(input int o, input int t, input logic s);
    img[o*NP+t] = s;
  endtask

  task automatic load(input logic [TOTAL-1:0] v, input int extra);
    for (int b = TOTAL-1; b >= 0; b--) begin
      @(negedge clk);
      if (b == TOTAL-2) check(cfg_done == 1'b0, "R5 clear on cfg_en rise", 32'(cfg_done), 0);
      if (b == TOTAL/2) check(pla_out == '0, "R6 zero while loading", 32'(pla_out), 0);
      cfg_en = 1'b1;
      cfg_data = v[b];
    end
    @(negedge clk);
    check(cfg_done == 1'b0, "R5 not early", 32'(cfg_done), 0);
    for (int e = 0; e < extra; e++) begin
      cfg_en = 1'b1;
      cfg_data = ~v[e % TOTAL];
      @(negedge clk);
      if (e == 0) begin
        check(cfg_done == 1'b1, "R5 done after last bit", 32'(cfg_done), 1);
        check(pla_out == '0, "R6 zero with cfg_en high", 32'(pla_out), 0);
      end
    end
    cfg_en = 1'b0;
    cfg_data = 1'b0;
    @(negedge clk);
    check(cfg_done == 1'b1, "R5 done high", 32'(cfg_done), 1);
  endtask

  task automatic sweep(input logic [TOTAL-1:0] v, input string req);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk);
      pla_in = NI'(x);
      #1;
      check(pla_out == model(v, NI'(x)), req, 32'(pla_out), 32'(model(v, NI'(x))));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    cfg_en = 1'b0;
    cfg_data = 1'b0;
    pla_in = '0;
    rng = 32'h1bad_c0de;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check(cfg_done == 1'b0, "R9 done after reset", 32'(cfg_done), 0);
    for (int x = 0; x < (1 << NI); x++) begin
      pla_in = NI'(x);
      #1;
      check(pla_out == '0, "R9 output after reset", 32'(pla_out), 0);
    end

    // R3: nothing selected gives zero even with always-true terms
    img = '0;
    load(img, 0);
    sweep(img, "R3 no terms selected");

    // R2: all-no-connect term is 1
    img = '0;
    set_sel(0, 0, 1'b1);
    load(img, 0);
    sweep(img, "R2 empty term true");

    // R1 R2 R3: xor via two terms, shared term, forced-off term
    img = '0;
    set_lit(0, 0, 2'b01); set_lit(0, 1, 2'b10);
    set_lit(1, 0, 2'b10); set_lit(1, 1, 2'b01);
    set_lit(2, 2, 2'b11);
    set_sel(0, 0, 1'b1); set_sel(0, 1, 1'b1);
    set_sel(1, 1, 1'b1); set_sel(1, 2, 1'b1);
    load(img, 0);
    sweep(img, "R1 R3 shared xor");
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk);
      pla_in = NI'(x);
      #1;
      check(pla_out[0] == (pla_in[0] ^ pla_in[1]), "R1 xor arithmetic", 32'(pla_out[0]), 32'(pla_in[0] ^ pla_in[1]));
      check(pla_out[1] == (!pla_in[0] && pla_in[1]), "R2 killed term absent", 32'(pla_out[1]), 32'(!pla_in[0] && pla_in[1]));
    end

    // R4: single literal per output at distinct positions (layout)
    img = '0;
    set_lit(3, 2, 2'b01); set_sel(1, 3, 1'b1);
    set_lit(1, 0, 2'b10); set_sel(0, 1, 1'b1);
    load(img, 0);
    for (int x = 0; x < (1 << NI); x++) begin
      @(negedge clk);
      pla_in = NI'(x);
      #1;
      check(pla_out == {pla_in[2], ~pla_in[0]}, "R4 bit layout", 32'(pla_out), 32'({pla_in[2], ~pla_in[0]}));
    end

    // R7: surplus bits ignored
    load(img, 5);
    sweep(img, "R7 surplus bits ignored");

    // R6: abandoned load keeps outputs at zero
    for (int b = 0; b < 7; b++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_data = b[0];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    check(cfg_done == 1'b0, "R6 done low after abandoned load", 32'(cfg_done), 0);
    for (int x = 0; x < (1 << NI); x++) begin
      pla_in = NI'(x);
      #1;
      check(pla_out == '0, "R6 zero after abandoned load", 32'(pla_out), 0);
    end

    // R8: pseudo-random configurations, same-cycle response
    for (int k = 0; k < 24; k++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      img = TOTAL'(rng);
      for (int t = 0; t < NP; t++)
        for (int i = 0; i < NI; i++)
          if (img[OR_BITS + (t*NI+i)*2 +: 2] == 2'b11 && rng[(t+i) % 32])
            set_lit(t, i, 2'b00);
      load(img, k % 3);
      sweep(img, "R8 random config");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule